// File: doc/BRIEF.md
# Two-wire EEPROM slave engine

This block is the serial front end of a small byte-addressed nonvolatile memory. It oversamples the two-wire bus (clock and data) in the system clock domain and finds start and stop conditions on those lines. It receives the device-select byte, acknowledges a matching device code and then runs the transaction. In the write direction that means a word address followed by data bytes. In the read direction it returns bytes for as long as the host acknowledges them.

The engine holds no memory array and no address counter of its own. It emits single-cycle strobes to a memory-side controller. One strobe loads an address, one hands over a received data byte, one commits the staged data, and one advances the read pointer. It samples the byte the controller presents on `rd_data_i`. A `busy_i` input from the controller marks a programming cycle in progress. While it is high the engine acknowledges nothing, so a host can poll the device address until an acknowledge comes back.

The parameter `ADDR_W` selects the memory size. With `ADDR_W = 9`, bit 1 of the device-select byte becomes address bit 8. With smaller values that bit is ignored and the word address is truncated.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset `sda_oe_o` is low and no strobe (`addr_load_o`, `wr_byte_o`, `commit_o`, `rd_next_o`) is asserted.
- R2: The device-select byte is bits [7:4] device code, bits [3:1] low select bits and bit 0 direction (1 = read). It is received MSB first after a start. Only code 4'b1010 is acknowledged, by holding `sda_oe_o` high across the ninth clock. Any other code gets no acknowledge, and later bytes up to the next start get neither acknowledge nor strobe.
- R3: In a write-direction transaction the word-address byte is acknowledged and `addr_load_o` pulses once. `addr_o` then equals {select bit 1, word address} for `ADDR_W = 9`.
- R4: Every data byte after the word address is acknowledged, and `wr_byte_o` pulses once with `wr_data_o` equal to the received byte.
- R5: A stop after at least one accepted data byte pulses `commit_o` once. A stop, or a repeated start, after only the word address loads the address but produces neither `wr_byte_o` nor `commit_o`. That is the dummy write.
- R6: After an acknowledged read select, the engine shifts out `rd_data_i` MSB first, changing its drive only while the clock is low. `rd_next_o` pulses once per byte, at the end of the byte's eighth bit.
- R7: A host acknowledge after a read byte makes the engine send the next byte. A missing host acknowledge releases the line until the next start. A stop returns to standby without `commit_o`.
- R8: While `busy_i` is high at the end of a byte, that byte gets no acknowledge and no strobe, and the engine stays silent until the next start.
- R9: A start seen in the middle of any byte discards the partial byte, clears the bit count and begins device-select reception again.
- R10: Each strobe lasts one cycle, and no two strobes occur in the same cycle. `commit_o` follows a stop, and the other strobes follow the clock falling edge that ends a byte's eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_oe_o | output | 1 | High pulls the data line low (open drain) |
| busy_i | input | 1 | Programming cycle in progress |
| addr_load_o | output | 1 | Load `addr_o` into the memory address counter |
| addr_o | output | ADDR_W | Address to load |
| wr_byte_o | output | 1 | Stage `wr_data_o` at the memory pointer |
| wr_data_o | output | 8 | Received data byte |
| commit_o | output | 1 | Start programming the staged bytes |
| rd_next_o | output | 1 | Advance the memory read pointer |
| rd_data_i | input | 8 | Byte at the memory read pointer |

## Verification
The checker watches every cycle for the strobe rules and for the link between strobes and `busy_i`. It also checks that the data drive only begins just after a clock falling edge and stays stable while the clock is high. Whether the right bytes are acknowledged, which address and data reach the memory side, and what is read back can only be shown by the bench scenarios. Those scenarios cover the sweep of all sixteen device codes, both values of the page bit, dummy writes, busy polling, read wrap-around and restarts in the middle of a byte.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } twi_st_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  assign scl_s = scl_ff[SYNC_N-1];
  assign sda_s = sda_ff[SYNC_N-1];

  // bus idles high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_o      = sda_s;
endmodule

// File: rtl/twi_bit_engine.sv
module twi_bit_engine
  import twi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              ack_req_i,
  input  logic              tx_load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              byte_done_o,
  output logic              slot_ack_o,
  output logic              slot_nack_o,
  output logic              slot_end_o,
  output logic              sda_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic              rose_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic              tx_on_q, ack_q;
  logic              in_slot, fall_ok;

  assign in_slot     = (cnt_q == ACK_SLOT);
  // ignore the falling edge that follows a start
  assign fall_ok     = scl_fall_i & rose_q;
  assign byte_done_o = fall_ok & (cnt_q == LAST_BIT);
  assign slot_end_o  = fall_ok & in_slot;
  assign slot_ack_o  = scl_rise_i & in_slot & ~sda_i;
  assign slot_nack_o = scl_rise_i & in_slot & sda_i;
  assign rx_byte_o   = rx_q;
  assign sda_oe_o    = ack_q | (tx_on_q & ~tx_q[BYTE_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rose_q  <= 1'b0;
      rx_q    <= '0;
      tx_q    <= '1;
      tx_on_q <= 1'b0;
      ack_q   <= 1'b0;
    end else if (start_i || stop_i) begin
      cnt_q   <= '0;
      rose_q  <= 1'b0;
      tx_on_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      if (scl_rise_i) begin
        rose_q <= 1'b1;
        if (!in_slot) rx_q <= {rx_q[BYTE_W-2:0], sda_i};
      end
      if (fall_ok) begin
        rose_q <= 1'b0;
        cnt_q  <= in_slot ? '0 : cnt_q + 1'b1;
        if (tx_on_q && cnt_q < LAST_BIT) tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
      end
      if (byte_done_o) tx_on_q <= 1'b0;
      if (ack_req_i)   ack_q   <= 1'b1;
      if (slot_end_o)  ack_q   <= 1'b0;
      if (tx_load_i) begin
        tx_q    <= tx_byte_i;
        tx_on_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/twi_xact_ctrl.sv
module twi_xact_ctrl
  import twi_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_done_i,
  input  logic              slot_ack_i,
  input  logic              slot_nack_i,
  input  logic              slot_end_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              ack_req_o,
  output logic              tx_load_o,
  output logic              addr_load_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_byte_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic              rd_next_o
);
  twi_st_e st_q;
  logic    wr_seen_q, rd_go_q;
  logic    load_q, wr_q, commit_q, rd_nx_q;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [BYTE_W-1:0] wdat_q;
  logic    code_ok, dev_ok;

  assign code_ok = (rx_byte_i[BYTE_W-1:BYTE_W-4] == DEV_CODE);
  assign dev_ok  = byte_done_i & ~busy_i & (st_q == ST_DEV) & code_ok;

  generate
    if (ADDR_W > BYTE_W) begin : g_page
      logic page_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     page_q <= 1'b0;
        else if (dev_ok) page_q <= rx_byte_i[1];
      end
      assign addr_n = {page_q, rx_byte_i};
    end else begin : g_flat
      assign addr_n = rx_byte_i[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    ack_req_o = 1'b0;
    if (byte_done_i && !busy_i) begin
      unique case (st_q)
        ST_DEV:           ack_req_o = code_ok;
        ST_WADR, ST_WDAT: ack_req_o = 1'b1;
        default:          ack_req_o = 1'b0;
      endcase
    end
  end

  assign tx_load_o = slot_end_i & (st_q == ST_RDAT) & rd_go_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      wr_seen_q <= 1'b0;
      rd_go_q   <= 1'b0;
      load_q    <= 1'b0;
      wr_q      <= 1'b0;
      commit_q  <= 1'b0;
      rd_nx_q   <= 1'b0;
      addr_q    <= '0;
      wdat_q    <= '0;
    end else begin
      load_q   <= 1'b0;
      wr_q     <= 1'b0;
      commit_q <= 1'b0;
      rd_nx_q  <= 1'b0;
      if (start_i) begin
        st_q      <= ST_DEV;
        wr_seen_q <= 1'b0;
        rd_go_q   <= 1'b0;
      end else if (stop_i) begin
        if (st_q == ST_WDAT && wr_seen_q) commit_q <= 1'b1;
        st_q      <= ST_IDLE;
        wr_seen_q <= 1'b0;
        rd_go_q   <= 1'b0;
      end else if (byte_done_i) begin
        if (busy_i) begin
          st_q    <= ST_SKIP;
          rd_go_q <= 1'b0;
        end else begin
          unique case (st_q)
            ST_DEV: begin
              if (!code_ok) st_q <= ST_SKIP;
              else if (rx_byte_i[0]) begin
                st_q    <= ST_RDAT;
                rd_go_q <= 1'b1;
              end else st_q <= ST_WADR;
            end
            ST_WADR: begin
              addr_q <= addr_n;
              load_q <= 1'b1;
              st_q   <= ST_WDAT;
            end
            ST_WDAT: begin
              wdat_q    <= rx_byte_i;
              wr_q      <= 1'b1;
              wr_seen_q <= 1'b1;
            end
            ST_RDAT: begin
              rd_nx_q <= 1'b1;
              rd_go_q <= 1'b0;
            end
            default: ;
          endcase
        end
      end else if (st_q == ST_RDAT) begin
        if (slot_ack_i) rd_go_q <= 1'b1;
        else if (slot_nack_i) st_q <= ST_SKIP;
        else if (slot_end_i && busy_i) begin
          st_q    <= ST_SKIP;
          rd_go_q <= 1'b0;
        end
      end
    end
  end

  assign addr_load_o = load_q;
  assign addr_o      = addr_q;
  assign wr_byte_o   = wr_q;
  assign wr_data_o   = wdat_q;
  assign commit_o    = commit_q;
  assign rd_next_o   = rd_nx_q;
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              busy_i,
  output logic              addr_load_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_byte_o,
  output logic [7:0]        wr_data_o,
  output logic              commit_o,
  output logic              rd_next_o,
  input  logic [7:0]        rd_data_i
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic byte_done, slot_ack, slot_nack, slot_end;
  logic ack_req, tx_load;
  logic [BYTE_W-1:0] rx_byte;

  twi_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .sda_o      (sda_s)
  );

  twi_bit_engine u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_i       (sda_s),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .ack_req_i   (ack_req),
    .tx_load_i   (tx_load),
    .tx_byte_i   (rd_data_i),
    .rx_byte_o   (rx_byte),
    .byte_done_o (byte_done),
    .slot_ack_o  (slot_ack),
    .slot_nack_o (slot_nack),
    .slot_end_o  (slot_end),
    .sda_oe_o    (sda_oe_o)
  );

  twi_xact_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .byte_done_i (byte_done),
    .slot_ack_i  (slot_ack),
    .slot_nack_i (slot_nack),
    .slot_end_i  (slot_end),
    .busy_i      (busy_i),
    .rx_byte_i   (rx_byte),
    .ack_req_o   (ack_req),
    .tx_load_o   (tx_load),
    .addr_load_o (addr_load_o),
    .addr_o      (addr_o),
    .wr_byte_o   (wr_byte_o),
    .wr_data_o   (wr_data_o),
    .commit_o    (commit_o),
    .rd_next_o   (rd_next_o)
  );
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic busy_i,
  input logic addr_load_o,
  input logic wr_byte_o,
  input logic commit_o,
  input logic rd_next_o,
  input logic stop_det,
  input logic byte_done,
  input logic scl_fall
);
  logic [2:0] hi_cnt;
  logic       byte_strobe;

  assign byte_strobe = addr_load_o | wr_byte_o | rd_next_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hi_cnt <= '0;
    else if (!scl_i)             hi_cnt <= '0;
    else if (hi_cnt != 3'd7)     hi_cnt <= hi_cnt + 1'b1;
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({addr_load_o, wr_byte_o, commit_o, rd_next_o})); // R10

  AST_STROBE_AT_BYTE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_strobe |-> $past(byte_done)); // R10

  AST_NO_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_strobe |-> !$past(busy_i)); // R8

  AST_COMMIT_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_det)); // R5

  AST_PULL_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall)); // R6

  AST_HOLD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && hi_cnt >= 3'd3) |-> $stable(sda_oe_o)); // R6
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_oe_o    (sda_oe_o),
  .busy_i      (busy_i),
  .addr_load_o (addr_load_o),
  .wr_byte_o   (wr_byte_o),
  .commit_o    (commit_o),
  .rd_next_o   (rd_next_o),
  .stop_det    (stop_det),
  .byte_done   (byte_done),
  .scl_fall    (scl_fall)
);

// File: tb/tb_twi_eeprom_slave.sv
`timescale 1ns/1ps
module tb_twi_eeprom_slave;
  localparam int AW = 9;
  localparam int MEM_N = 1 << AW;
  localparam int Q = 8;
  localparam int BUSY_CYC = 2000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_w;
  logic busy;
  logic addr_load, wr_byte, commit, rd_next;
  logic [AW-1:0] addr;
  logic [7:0] wr_data, rd_data;

  always #10 clk_i = ~clk_i;

  assign sda_w = sda_m & ~sda_oe;

  twi_eeprom_slave #(.ADDR_W(AW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_w),
    .sda_oe_o(sda_oe), .busy_i(busy),
    .addr_load_o(addr_load), .addr_o(addr),
    .wr_byte_o(wr_byte), .wr_data_o(wr_data),
    .commit_o(commit), .rd_next_o(rd_next), .rd_data_i(rd_data)
  );

  // memory-side model
  logic [7:0] mem [MEM_N];
  logic [7:0] stg [MEM_N];
  logic       stgv [MEM_N];
  logic [AW-1:0] ptr;
  int busy_cnt;
  int n_load, n_wr, n_commit, n_rd, n_multi;
  logic [AW-1:0] last_addr;
  logic [7:0] last_wdata;

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  assign rd_data = mem[ptr];
  assign busy = (busy_cnt != 0);

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = init_val(i);
      stgv[i] = 1'b0;
      stg[i] = '0;
    end
    ptr = '0; busy_cnt = 0;
    n_load = 0; n_wr = 0; n_commit = 0; n_rd = 0; n_multi = 0;
    last_addr = '0; last_wdata = '0;
  end

  always @(posedge clk_i) begin
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if ((int'(addr_load) + int'(wr_byte) + int'(commit) + int'(rd_next)) > 1) n_multi <= n_multi + 1;
    if (addr_load) begin
      ptr <= addr; last_addr <= addr; n_load <= n_load + 1;
      for (int i = 0; i < MEM_N; i++) stgv[i] <= 1'b0;
    end
    if (wr_byte) begin
      stg[ptr] <= wr_data; stgv[ptr] <= 1'b1;
      ptr <= {ptr[AW-1:4], ptr[3:0] + 4'd1};
      last_wdata <= wr_data; n_wr <= n_wr + 1;
    end
    if (commit) begin
      for (int i = 0; i < MEM_N; i++) if (stgv[i]) begin mem[i] <= stg[i]; stgv[i] <= 1'b0; end
      busy_cnt <= BUSY_CYC; n_commit <= n_commit + 1;
    end
    if (rd_next) begin ptr <= ptr + 1'b1; n_rd <= n_rd + 1; end
  end

  // expectation kept by the test sequence
  int exp_mem [MEM_N];
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2 * Q); scl_m = 0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = ~sda_w; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1; tick(Q); b[i] = sda_w; tick(Q); scl_m = 0; tick(Q);
    end
    sda_m = ~mack; tick(Q); scl_m = 1; tick(2 * Q); scl_m = 0; tick(Q); sda_m = 1;
  endtask

  function automatic logic [7:0] dev(input logic p, input logic rd);
    return {4'b1010, 2'b00, p, rd};
  endfunction

  // write n bytes starting at {p,wa}; data base+k
  task automatic write_seq(input logic p, input logic [7:0] wa, input int n, input int base);
    logic a;
    int l0, w0, c0;
    int pa;
    l0 = n_load; w0 = n_wr; c0 = n_commit;
    pa = {p, wa};
    bus_start();
    send_byte(dev(p, 0), a); chk("R2 select ack", a, 1);
    send_byte(wa, a);        chk("R3 word addr ack", a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(8'(base + k), a); chk("R4 data ack", a, 1);
      exp_mem[(pa & 'h1F0) | ((pa + k) & 'hF)] = (base + k) & 255;
    end
    bus_stop(); tick(4);
    chk("R3 addr_load count", n_load - l0, 1);
    chk("R3 addr value", int'(last_addr), pa);
    chk("R4 wr_byte count", n_wr - w0, n);
    chk("R4 last data", int'(last_wdata), (base + n - 1) & 255);
    chk("R5 commit count", n_commit - c0, 1);
  endtask

  // dummy write then repeated start and sequential read of n bytes
  task automatic rand_read(input logic p, input logic [7:0] wa, input int n);
    logic a;
    logic [7:0] b;
    int r0, c0, w0;
    int pa;
    r0 = n_rd; c0 = n_commit; w0 = n_wr;
    pa = {p, wa};
    bus_start();
    send_byte(dev(p, 0), a); chk("R2 select ack", a, 1);
    send_byte(wa, a);        chk("R3 word addr ack", a, 1);
    bus_start();
    send_byte(dev(p, 1), a); chk("R6 read select ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk("R6 R7 read data", int'(b), exp_mem[(pa + k) % MEM_N]);
    end
    bus_stop(); tick(4);
    chk("R6 rd_next count", n_rd - r0, n);
    chk("R5 dummy write no commit", n_commit - c0, 0);
    chk("R5 dummy write no data", n_wr - w0, 0);
    chk("R7 line released", int'(sda_oe), 0);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    int l0, w0, c0, r0;
    for (int i = 0; i < MEM_N; i++) exp_mem[i] = int'(init_val(i));
    tick(5);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    rst_ni = 1'b1;
    tick(5);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 no strobes", n_load + n_wr + n_commit + n_rd, 0);

    // sweep every device code
    for (int c = 0; c < 16; c++) begin
      l0 = n_load; c0 = n_commit;
      bus_start();
      send_byte({4'(c), 4'b0000}, a);
      chk("R2 code sweep ack", a, c == 10);
      send_byte(8'h10, a);
      chk("R2 R5 second byte", a, c == 10);
      bus_stop(); tick(4);
      chk("R2 R5 load after sweep", n_load - l0, c == 10);
      chk("R5 stop after address no commit", n_commit - c0, 0);
    end

    // byte writes across both page-bit values
    for (int p = 0; p < 2; p++) begin
      for (int j = 0; j < 3; j++) begin
        logic [7:0] wa;
        wa = (j == 0) ? 8'h00 : (j == 1) ? 8'h5A : 8'hFF;
        write_seq(p[0], wa, 1, 16'h30 + p * 7 + j * 3);
        tick(BUSY_CYC + 100);
        rand_read(p[0], wa, 1);
      end
    end

    // page write then sequential read
    write_seq(1'b1, 8'h20, 5, 'hC0);
    tick(BUSY_CYC + 100);
    rand_read(1'b1, 8'h20, 5);

    // busy polling
    write_seq(1'b0, 8'h33, 1, 'h5E);
    l0 = n_load; w0 = n_wr; r0 = n_rd;
    bus_start();
    send_byte(dev(0, 1), a); chk("R8 no ack while busy", a, 0);
    recv_byte(1'b1, b);      chk("R8 line silent while busy", int'(b), 'hFF);
    bus_start();
    send_byte(dev(0, 0), a); chk("R8 write select while busy", a, 0);
    send_byte(8'h44, a);     chk("R8 word addr while busy", a, 0);
    bus_stop(); tick(4);
    chk("R8 no strobes while busy", (n_load - l0) + (n_wr - w0) + (n_rd - r0), 0);
    tick(BUSY_CYC + 100);
    bus_start();
    send_byte(dev(0, 1), a); chk("R8 ack after busy", a, 1);
    recv_byte(1'b0, b);      chk("R6 current address read", int'(b), exp_mem['h034]);
    recv_byte(1'b0, b);      chk("R7 released after nack", int'(b), 'hFF);
    bus_stop(); tick(4);

    // sequential read wrap across top of memory
    rand_read(1'b1, 8'hFD, 6);

    // restart in the middle of a device byte
    bus_start();
    send_bits(8'hA0, 3);
    rand_read(1'b1, 8'h21, 2);
    chk("R9 restart mid select", 1, 1);

    // restart in the middle of a data byte
    w0 = n_wr; c0 = n_commit;
    bus_start();
    send_byte(dev(0, 0), a); chk("R9 select ack", a, 1);
    send_byte(8'h5A, a);     chk("R9 word addr ack", a, 1);
    send_bits(8'h00, 5);
    bus_start();
    send_byte(dev(0, 1), a); chk("R9 reselect ack", a, 1);
    recv_byte(1'b0, b);      chk("R9 data after restart", int'(b), exp_mem['h05A]);
    bus_stop(); tick(4);
    chk("R9 partial byte dropped", n_wr - w0, 0);
    chk("R9 R7 no commit", n_commit - c0, 0);

    chk("R10 single strobe per cycle", n_multi, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule